// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block sits beside a processor core and decides when an interrupt is taken. It watches seven request lines (levels 1 to 7) and compares the highest one with the 3-bit priority mask held in the status word it owns. A level is taken only if it is above the mask. Level 7 is the exception: it is taken on each rising edge whatever the mask says. Software traps and return-from-exception requests from the core start the same kind of sequence.

When a request is taken, the block does the following in order:
- It saves the core's program counter and then the old status word on a stack that lives in external memory.
- It sets supervisor mode and, for hardware levels, raises the mask to the level it took.
- It works out the vector number and fetches the handler address from the vector table.
- It gives the core the new program counter with a one-cycle redirect pulse.

A return reverses the save. It reads back the status word and then the program counter, and it releases the stack space. All memory traffic goes over one simple request/acknowledge port, and a request is held until it is acknowledged.

Top module: `intr_level_ctrl`

## Requirements
- R1: After reset the status word is 16'h2700 (supervisor bit 13 set, mask bits 10:8 = 7), the stack pointer is SP_INIT (default 32'h8000), and busy and mem_req are low.
- R2: A request on levels 1 to 6 is taken only when its level is strictly greater than the mask. When several levels are raised at once, the highest one is taken. A request that is not taken starts no memory traffic and leaves the status word unchanged.
- R3: A rising edge on level 7 is taken even when the mask is 7. A level-7 line that stays high is taken only once, and it must fall and rise again to be taken again.
- R4: The save sequence does two writes, in this order:
  - the 32-bit program counter at sp-4;
  - then the 16-bit status word as it was before the request was taken, at sp-6.
  After the sequence the stack pointer is sp-6.
- R5: When a hardware level L is taken, the status word becomes the old word with bit 13 set and bits 10:8 set to L. The other bits do not change.
- R6: The vector number comes from one of three sources:
  - for a hardware level with iack_auto high, it is 24+L;
  - for a hardware level with iack_auto low, it is iack_vec;
  - for a trap with number n, it is 32+n.
  A trap sets bit 13 and leaves the mask as it was. The handler is read as a 32-bit word at vector×4, and it appears on new_pc together with a one-cycle redirect pulse.
- R7: A return reads the 16-bit status word at sp into the status register, then reads the 32-bit program counter at sp+2 and redirects to it. The stack pointer then grows by 6, so the saved status and program counter are restored exactly.
- R8: Requests are taken only while the block is idle. The priority order is: a hardware interrupt first, then rte_req, then trap_req, then sr_load.
- R9: When the block is idle and no other request is taken, sr_load writes sr_wdata into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 7 | Request lines; bit i is level i (bits 7:1) |
| iack_auto | input | 1 | Selects the automatic vector 24+level for a hardware level |
| iack_vec | input | 8 | Vector number supplied by the device when iack_auto is low |
| trap_req | input | 1 | Software trap request |
| trap_num | input | 4 | Trap number 0 to 15 |
| rte_req | input | 1 | Return-from-exception request |
| sr_load | input | 1 | Write the status word from the core |
| sr_wdata | input | 16 | New status word value |
| pc_in | input | 32 | Core program counter to save |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit access (low half of the data) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid together with mem_ack |
| mem_ack | input | 1 | Access complete |
| sr | output | 16 | Current status word |
| sp | output | 32 | Current stack pointer |
| busy | output | 1 | A save, fetch or return sequence is in progress |
| redirect | output | 1 | One-cycle pulse: new_pc is valid |
| new_pc | output | 32 | Handler address or restored program counter |

## Verification
A wrong mask comparison, or a wrong level-7 pending flag, shows at the ports within two cycles. Either busy rises when it should stay low, or it stays low when a request should be taken. A wrong saved status word or stack pointer does not show until the return sequence completes: the restored sr, sp and new_pc then differ from the values before the request. A wrong vector shows at the first redirect, because new_pc points to the wrong entry of the vector table.

// File: rtl/intr_level_ctrl.sv
module intr_level_ctrl #(
  parameter logic [31:0] SP_INIT   = 32'h0000_8000,
  parameter logic [7:0]  AUTO_BASE = 8'd24,
  parameter logic [7:0]  TRAP_BASE = 8'd32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:1]  irq,
  input  logic        iack_auto,
  input  logic [7:0]  iack_vec,
  input  logic        trap_req,
  input  logic [3:0]  trap_num,
  input  logic        rte_req,
  input  logic        sr_load,
  input  logic [15:0] sr_wdata,
  input  logic [31:0] pc_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_long,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [15:0] sr,
  output logic [31:0] sp,
  output logic        busy,
  output logic        redirect,
  output logic [31:0] new_pc
);

  typedef enum logic [2:0] {IDLE, PUSH_PC, PUSH_SR, FETCH, POP_SR, POP_PC} st_t;

  st_t         st;
  logic [15:0] sr_q, sr_sv;
  logic [31:0] sp_q, pc_q, npc_q;
  logic [7:0]  vec_q;
  logic        nmi_pend, irq7_q, redir_q;
  logic [2:0]  mlvl, acc_lvl;
  logic        idle, take_irq, take_rte;

  always_comb begin
    mlvl = 3'd0;
    for (int i = 1; i < 7; i++)
      if (irq[i]) mlvl = 3'(i);
  end

  assign idle     = (st == IDLE);
  assign take_irq = idle && (nmi_pend || (mlvl > sr_q[10:8]));
  assign take_rte = idle && !take_irq && rte_req;
  assign acc_lvl  = nmi_pend ? 3'd7 : mlvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      sr_q     <= 16'h2700;
      sp_q     <= SP_INIT;
      pc_q     <= '0;
      sr_sv    <= '0;
      vec_q    <= '0;
      npc_q    <= '0;
      nmi_pend <= 1'b0;
      irq7_q   <= 1'b0;
      redir_q  <= 1'b0;
    end else begin
      irq7_q   <= irq[7];
      nmi_pend <= (nmi_pend && !take_irq) || (irq[7] && !irq7_q);
      redir_q  <= 1'b0;
      case (st)
        IDLE: begin
          if (take_irq) begin
            pc_q  <= pc_in;
            sr_sv <= sr_q;
            vec_q <= iack_auto ? AUTO_BASE + {5'd0, acc_lvl} : iack_vec;
            sr_q  <= {sr_q[15:14], 1'b1, sr_q[12:11], acc_lvl, sr_q[7:0]};
            st    <= PUSH_PC;
          end else if (take_rte) begin
            st <= POP_SR;
          end else if (trap_req) begin
            pc_q     <= pc_in;
            sr_sv    <= sr_q;
            vec_q    <= TRAP_BASE + {4'd0, trap_num};
            sr_q[13] <= 1'b1;
            st       <= PUSH_PC;
          end else if (sr_load) begin
            sr_q <= sr_wdata;
          end
        end
        PUSH_PC: if (mem_ack) st <= PUSH_SR;
        PUSH_SR: if (mem_ack) begin
          sp_q <= sp_q - 32'd6;
          st   <= FETCH;
        end
        FETCH: if (mem_ack) begin
          npc_q   <= mem_rdata;
          redir_q <= 1'b1;
          st      <= IDLE;
        end
        POP_SR: if (mem_ack) begin
          sr_q <= mem_rdata[15:0];
          st   <= POP_PC;
        end
        POP_PC: if (mem_ack) begin
          npc_q   <= mem_rdata;
          redir_q <= 1'b1;
          sp_q    <= sp_q + 32'd6;
          st      <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      PUSH_PC: mem_addr = sp_q - 32'd4;
      PUSH_SR: mem_addr = sp_q - 32'd6;
      FETCH:   mem_addr = {22'd0, vec_q, 2'b00};
      POP_PC:  mem_addr = sp_q + 32'd2;
      default: mem_addr = sp_q;
    endcase
  end

  assign mem_req   = !idle;
  assign mem_we    = (st == PUSH_PC) || (st == PUSH_SR);
  assign mem_long  = (st == PUSH_PC) || (st == FETCH) || (st == POP_PC);
  assign mem_wdata = (st == PUSH_PC) ? pc_q : {16'd0, sr_sv};
  assign sr        = sr_q;
  assign sp        = sp_q;
  assign busy      = !idle;
  assign redirect  = redir_q;
  assign new_pc    = npc_q;

endmodule

// File: rtl/intr_level_ctrl_chk.sv
module intr_level_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        redirect,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [15:0] sr
);

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (sr == 16'h2700 && !busy)); // R1
  AST_MASK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (sr[10:8] >= $past(sr[10:8]))); // R2
  AST_PUSH_SUPER: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> sr[13]); // R5
  AST_REDIRECT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) redirect |-> $past(mem_ack)); // R6
  AST_END_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> redirect); // R7

endmodule

bind intr_level_ctrl intr_level_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .redirect(redirect),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .sr(sr)
);

// File: tb/intr_level_ctrl_test.sv
module intr_level_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:1]  irq = '0;
  logic        iack_auto = 1'b1, trap_req = 1'b0, rte_req = 1'b0, sr_load = 1'b0;
  logic [7:0]  iack_vec = '0;
  logic [3:0]  trap_num = '0;
  logic [15:0] sr_wdata = '0;
  logic [31:0] pc_in = '0;
  logic        mem_req, mem_we, mem_long, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [15:0] sr;
  logic [31:0] sp, new_pc;
  logic        busy, redirect;

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0;
  logic [31:0] rd_pc = '0;
  bit busy_seen = 0;
  logic [7:0] mem [int unsigned];

  intr_level_ctrl uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] handler(input logic [7:0] v);
    return 32'h0001_0000 + {24'd0, v} * 32'h10;
  endfunction
  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rdb(a), rdb(a + 1), rdb(a + 2), rdb(a + 3)};
  endfunction
  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {rdb(a), rdb(a + 1)};
  endfunction
  function automatic logic [2:0] top_level(input logic [7:1] l);
    logic [2:0] r = 3'd0;
    for (int i = 1; i <= 7; i++) if (l[i]) r = 3'(i);
    return r;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (redirect) begin rd_cnt++; rd_pc = new_pc; end
    if (busy) busy_seen = 1;
    mem_ack = 1'b0;
    if (mem_req && ($urandom % 3) != 0) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (mem_long) for (int b = 0; b < 4; b++) mem[mem_addr + b] = mem_wdata[31 - 8*b -: 8];
        else begin mem[mem_addr] = mem_wdata[15:8]; mem[mem_addr + 1] = mem_wdata[7:0]; end
      end else mem_rdata = mem_long ? rd32(mem_addr) : {16'd0, rd16(mem_addr)};
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog R8 act=%0d exp=%0d", cyc, 0);
      summary();
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic set_sr(input logic [15:0] v);
    sr_load = 1'b1; sr_wdata = v; step(); sr_load = 1'b0; step();
  endtask

  task automatic wait_redir(input string req);
    int base = rd_cnt;
    for (int k = 0; k < 300 && rd_cnt == base; k++) step();
    chk(rd_cnt != base, req, rd_cnt, base + 1);
  endtask

  task automatic do_rte(input logic [31:0] pc, input logic [15:0] osr, input logic [31:0] sp0);
    rte_req = 1'b1; step(); rte_req = 1'b0;
    wait_redir("R7 rte redirect");
    chk(rd_pc == pc, "R7 restored pc", rd_pc, pc);
    chk(sr == osr, "R7 restored sr", sr, osr);
    chk(sp == sp0, "R7 restored sp", sp, sp0);
  endtask

  task automatic check_stack(input logic [31:0] sp0, input logic [31:0] pc, input logic [15:0] osr);
    chk(sp == sp0 - 6, "R4 sp after save", sp, sp0 - 6);
    chk(rd32(sp0 - 4) == pc, "R4 pushed pc", rd32(sp0 - 4), pc);
    chk(rd16(sp0 - 6) == osr, "R4 pushed sr", rd16(sp0 - 6), osr);
  endtask

  task automatic int_case(input logic [2:0] m, input logic [7:1] lines, input bit aut,
                          input logic [7:0] vin, input logic [31:0] pc, input logic [15:0] rnd);
    logic [15:0] osr = {rnd[15:11], m, rnd[7:0]};
    logic [31:0] sp0;
    logic [2:0] lv = top_level(lines);
    logic [7:0] ev = aut ? 8'd24 + {5'd0, lv} : vin;
    set_sr(osr);
    sp0 = sp;
    pc_in = pc; iack_auto = aut; iack_vec = vin; busy_seen = 0; irq = lines;
    if (lv <= m) begin
      repeat (4) step();
      chk(!busy_seen, "R2 masked level not taken", busy_seen, 0);
      chk(sr == osr, "R2 sr untouched", sr, osr);
      irq = '0; step();
    end else begin
      wait_redir("R2 level taken");
      chk(rd_pc == handler(ev), "R6 handler", rd_pc, handler(ev));
      chk(sr == {osr[15:14], 1'b1, osr[12:11], lv, osr[7:0]}, "R5 new sr", sr,
          {osr[15:14], 1'b1, osr[12:11], lv, osr[7:0]});
      check_stack(sp0, pc, osr);
      irq = '0; step();
      do_rte(pc, osr, sp0);
    end
  endtask

  task automatic trap_case(input logic [3:0] n, input logic [31:0] pc, input logic [15:0] osr);
    logic [31:0] sp0;
    set_sr(osr);
    sp0 = sp; pc_in = pc;
    trap_req = 1'b1; trap_num = n; step(); trap_req = 1'b0;
    wait_redir("R6 trap redirect");
    chk(rd_pc == handler(8'd32 + {4'd0, n}), "R6 trap handler", rd_pc, handler(8'd32 + {4'd0, n}));
    chk(sr == (osr | 16'h2000), "R6 trap keeps mask", sr, osr | 16'h2000);
    check_stack(sp0, pc, osr);
    do_rte(pc, osr, sp0);
  endtask

  initial begin
    logic [31:0] sp0;
    void'($urandom(32'd20240611));
    for (int v = 0; v < 256; v++)
      for (int b = 0; b < 4; b++) mem[v*4 + b] = handler(8'(v))[31 - 8*b -: 8];
    repeat (3) step();
    rst_n = 1'b1; step();
    chk(sr == 16'h2700, "R1 reset sr", sr, 16'h2700);
    chk(sp == 32'h8000, "R1 reset sp", sp, 32'h8000);
    chk(!busy && !mem_req, "R1 reset idle", {busy, mem_req}, 0);

    set_sr(16'h0512);
    chk(sr == 16'h0512, "R9 sr load", sr, 16'h0512);

    int_case(3'd2, 7'b0000100, 1'b1, 8'd0, 32'h0000_1234, 16'h0000);
    int_case(3'd3, 7'b0000100, 1'b1, 8'd0, 32'h0000_2000, 16'h0000);
    int_case(3'd0, 7'b0101010, 1'b0, 8'd200, 32'hdead_0000, 16'hffff);
    int_case(3'd6, 7'b0111111, 1'b1, 8'd0, 32'h0000_0040, 16'h0000);

    set_sr(16'h2700); sp0 = sp; pc_in = 32'h0000_7000; iack_auto = 1'b1;
    irq = 7'b1000000;
    wait_redir("R3 nmi taken at mask 7");
    chk(rd_pc == handler(8'd31), "R3 nmi vector", rd_pc, handler(8'd31));
    do_rte(32'h0000_7000, 16'h2700, sp0);
    busy_seen = 0; repeat (6) step();
    chk(!busy_seen, "R3 held line taken once", busy_seen, 0);
    irq = '0; step(); step(); irq = 7'b1000000;
    wait_redir("R3 new edge taken");
    do_rte(32'h0000_7000, 16'h2700, sp0);
    irq = '0; step();

    trap_case(4'd0, 32'h0000_0100, 16'h0300);
    trap_case(4'd15, 32'h0000_0200, 16'h2500);

    set_sr(16'h2000); sp0 = sp; pc_in = 32'h0000_3000; iack_auto = 1'b1;
    irq = 7'b0000100; rte_req = 1'b1; step(); rte_req = 1'b0;
    wait_redir("R8 interrupt beats rte");
    chk(rd_pc == handler(8'd27), "R8 interrupt first", rd_pc, handler(8'd27));
    irq = '0; step();
    do_rte(32'h0000_3000, 16'h2000, sp0);

    for (int it = 0; it < 60; it++) begin
      if ($urandom % 4 == 3)
        trap_case(4'($urandom), {$urandom} & 32'hffff_fffe, 16'($urandom) & 16'hdfff);
      else
        int_case(3'($urandom), 7'($urandom) & 7'h3f, 1'($urandom), 8'd64 + 8'($urandom % 192),
                 {$urandom} & 32'hffff_fffe, 16'($urandom));
    end
    summary();
  end
endmodule